// File: doc/BRIEF.md
# Burst SRAM with Posted Writes

This block models a pipelined burst static RAM in which every access moves four words. The host issues a command on one cycle by pulling the active-low load strobe down. The read/write select and the address are sampled with it. The block then walks the four words of the aligned four-word line. It starts at the word named by the two low address bits and steps upward, wrapping within the line. One clock runs at the beat rate, so every beat takes exactly one cycle.

Write data does not go into the array at once. Each beat is parked in a four-slot posted-write buffer, one slot per word offset. A slot is written into the array only when a later write burst reaches the same offset and takes the slot over. Reads look up the buffer on every beat. Bytes that the pending write enabled come from the buffer, and all other bytes come from the array. A read therefore always sees the latest data, even straight after a write. Read data is registered. The output-enable is high only while read beats are being driven, and the data outputs are held at zero the rest of the time.

Top module: `burst_sram`

## Requirements
- R1: A write burst begins in a cycle where no burst is running and `ld_ni` and `rw_i` are both 0. The first data beat and its byte selects are taken from `wdata_i`/`bw_ni` in that same cycle, and beats 2 to 4 are taken in the three following cycles.
- R2: Every accepted command makes exactly four beats. All four beats use the upper address bits `addr_i[AW-1:2]` captured with the command.
- R3: Beat k (k = 0..3) uses word offset (`addr_i[1:0]` + k) mod 4. A start of 1 gives 1,2,3,0 and a start of 2 gives 2,3,0,1.
- R4: `bw_ni` is active low, with bit b covering data bits [8b+7:8b]. A write beat changes only the bytes whose select is 0. With `bw_ni` = 4'b1110 only the lowest byte is written and the other three keep their earlier values.
- R5: A write beat is held in the posted-write buffer. The array is written only during a later write beat with the same word offset, which commits the older entry of that slot.
- R6: A read returns the most recent data for each byte, including writes still held in the buffer. This also holds when the read command directly follows the last beat of a write to the same words. Partly masked pending writes are merged byte by byte with the array contents.
- R7: When no read beat is being output, `oe_o` and `rvalid_o` are 0 and `rdata_o` is all zeros.
- R8: A read burst begins when no burst is running, `ld_ni` is 0 and `rw_i` is 1. The data for beat k appears on `rdata_o` in the cycle after beat k, so four consecutive cycles carry data with `rvalid_o` and `oe_o` both 1.
- R9: With `ld_ni` at 1 and no burst running, the block is deselected and nothing is written. While a burst is running, `ld_ni`, `rw_i` and `addr_i` are ignored.
- R10: After reset the buffer is empty, the array reads as all zeros, and all outputs are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Beat-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_ni | input | 1 | Command strobe, active low |
| rw_i | input | 1 | 1 = read, 0 = write, sampled with the command |
| addr_i | input | AW | Word address; low two bits pick the starting word |
| wdata_i | input | DW | Write data for the current beat |
| bw_ni | input | NB | Byte-write selects, active low |
| rdata_o | output | DW | Read data, zero when idle |
| rvalid_o | output | 1 | Read data valid |
| oe_o | output | 1 | Output enable for the read-data bus |

## Verification
The hardest case is a read that must merge three sources in one word. These are the bytes of a partly masked write still held in the buffer, and array bytes that were themselves committed from an earlier partial write. The stimulus reaches this case in three steps. It writes a line, and then writes a different line at the same offsets so that the first line is pushed into the array. It then issues a masked write to the first line and reads it on the very next cycle. Separate directed sequences pull the strobe low in the middle of a read burst and hold it high with write data present. A read-back then shows that neither disturbed the stored contents.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef logic [1:0] beat_t;  // word offset within a four-word line
endpackage

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int AW = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ld_ni,
  input  logic                rw_i,
  input  logic [AW-1:0]       addr_i,
  output logic                op_valid_o,
  output logic                op_rd_o,
  output sram_pkg::beat_t     beat_o,
  output logic [AW-1:0]       addr_o
);
  localparam int LW = AW - 2;

  sram_pkg::beat_t cnt_q;
  sram_pkg::beat_t start_q;
  logic [LW-1:0]   line_q;
  logic            rd_q;
  logic            busy, cmd;

  assign busy = (cnt_q != 2'd0);
  assign cmd  = !ld_ni && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      start_q <= '0;
      line_q  <= '0;
      rd_q    <= 1'b0;
    end else if (cmd) begin
      cnt_q   <= 2'd1;
      start_q <= addr_i[1:0];
      line_q  <= addr_i[AW-1:2];
      rd_q    <= rw_i;
    end else if (busy) begin
      cnt_q   <= cnt_q + 2'd1;  // wraps to 0 after the fourth beat
    end
  end

  always_comb begin
    op_valid_o = busy || cmd;
    op_rd_o    = busy ? rd_q : rw_i;
    beat_o     = busy ? cnt_q : 2'd0;
    addr_o     = busy ? {line_q, 2'(start_q + cnt_q)} : addr_i;
  end

  AST_BURST_WALK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && beat_o != 2'd3) |=> (op_valid_o
      && addr_o[AW-1:2] == $past(addr_o[AW-1:2])
      && addr_o[1:0] == 2'($past(addr_o[1:0]) + 2'd1))); // R2 R3

  AST_BURST_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && beat_o == 2'd3) |=> (beat_o == 2'd0)); // R2
endmodule

// File: rtl/post_buf.sv
module post_buf #(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter int NB = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [NB-1:0]   be_i,
  input  logic [DW-1:0]   arr_rdata_i,
  output logic [DW-1:0]   fwd_data_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  output logic [NB-1:0]   mem_be_o
);
  localparam int LW = AW - 2;
  localparam int BW = DW / NB;

  logic [3:0]    v_q;
  logic [LW-1:0] tag_q  [4];
  logic [DW-1:0] data_q [4];
  logic [NB-1:0] be_q   [4];

  sram_pkg::beat_t off;
  logic [LW-1:0]   line;
  logic            hit;

  assign off  = addr_i[1:0];
  assign line = addr_i[AW-1:2];
  assign hit  = v_q[off] && (tag_q[off] == line);

  // Commit the older entry of the slot this write beat takes over
  assign mem_we_o    = wr_i && v_q[off];
  assign mem_addr_o  = {tag_q[off], off};
  assign mem_wdata_o = data_q[off];
  assign mem_be_o    = be_q[off];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
      for (int o = 0; o < 4; o++) begin
        tag_q[o]  <= '0;
        data_q[o] <= '0;
        be_q[o]   <= '0;
      end
    end else if (wr_i) begin
      v_q[off]    <= 1'b1;
      tag_q[off]  <= line;
      data_q[off] <= wdata_i;
      be_q[off]   <= be_i;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_merge
    assign fwd_data_o[b*BW +: BW] = (hit && be_q[off][b]) ? data_q[off][b*BW +: BW]
                                                          : arr_rdata_i[b*BW +: BW];
  end

  AST_COMMIT_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> wr_i); // R5

  AST_SLOT_FILLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> v_q[$past(off)]); // R5
endmodule

// File: rtl/sram_array.sv
module sram_array #(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter int NB = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [NB-1:0]   be_i,
  input  logic [AW-1:0]   raddr_i,
  output logic [DW-1:0]   rdata_o
);
  localparam int DEPTH = 1 << AW;
  localparam int BW    = DW / NB;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
    end else if (we_i) begin
      for (int b = 0; b < NB; b++)
        if (be_i[b]) mem[waddr_i][b*BW +: BW] <= wdata_i[b*BW +: BW];
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int AW = 6,
  parameter int DW = 32,
  parameter int NB = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ld_ni,
  input  logic            rw_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [NB-1:0]   bw_ni,
  output logic [DW-1:0]   rdata_o,
  output logic            rvalid_o,
  output logic            oe_o
);
  logic            op_valid, op_rd, wr_beat, rd_beat;
  sram_pkg::beat_t beat;
  logic [AW-1:0]   op_addr;
  logic            mem_we;
  logic [AW-1:0]   mem_addr;
  logic [DW-1:0]   mem_wdata, arr_rdata, fwd_data;
  logic [NB-1:0]   mem_be;
  logic [DW-1:0]   rdata_q;
  logic            rvalid_q;

  burst_seq #(.AW(AW)) u_seq (
    .clk_i, .rst_ni, .ld_ni, .rw_i, .addr_i,
    .op_valid_o(op_valid), .op_rd_o(op_rd), .beat_o(beat), .addr_o(op_addr)
  );

  assign wr_beat = op_valid && !op_rd;
  assign rd_beat = op_valid && op_rd;

  post_buf #(.AW(AW), .DW(DW), .NB(NB)) u_buf (
    .clk_i, .rst_ni,
    .wr_i(wr_beat), .addr_i(op_addr), .wdata_i, .be_i(~bw_ni),
    .arr_rdata_i(arr_rdata), .fwd_data_o(fwd_data),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_be_o(mem_be)
  );

  sram_array #(.AW(AW), .DW(DW), .NB(NB)) u_arr (
    .clk_i, .rst_ni,
    .we_i(mem_we), .waddr_i(mem_addr), .wdata_i(mem_wdata), .be_i(mem_be),
    .raddr_i(op_addr), .rdata_o(arr_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd_beat;
      rdata_q  <= rd_beat ? fwd_data : '0;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign oe_o     = rvalid_q;

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> (rdata_o == '0)); // R7

  AST_READ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_beat && beat == 2'd0) |=> rvalid_o); // R8

  AST_DESELECT_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_valid |-> !mem_we); // R9

  AST_NO_COMMIT_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_rd |-> !mem_we); // R5
endmodule

// File: tb/tb_burst_sram.sv
module tb_burst_sram;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int NB = 4;
  localparam int NV = 13;

  // {op(1=write,2=read), addr, data base, bw_n}
  localparam logic [43:0] VEC [NV] = '{
    {2'd1, 6'h04, 32'hA000_0000, 4'h0},
    {2'd2, 6'h04, 32'h0, 4'h0},
    {2'd2, 6'h05, 32'h0, 4'h0},
    {2'd1, 6'h0A, 32'hB000_0010, 4'h0},
    {2'd2, 6'h08, 32'h0, 4'h0},
    {2'd1, 6'h04, 32'hC0C0_C0C0, 4'hE},
    {2'd2, 6'h07, 32'h0, 4'h0},
    {2'd1, 6'h0B, 32'hD1D2_D3D4, 4'h5},
    {2'd2, 6'h0B, 32'h0, 4'h0},
    {2'd2, 6'h06, 32'h0, 4'h0},
    {2'd1, 6'h3F, 32'h1234_5678, 4'h0},
    {2'd2, 6'h3C, 32'h0, 4'h0},
    {2'd2, 6'h10, 32'h0, 4'h0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_n = 1'b1;
  logic rw = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [NB-1:0] bw_n = '1;
  logic [DW-1:0] rdata;
  logic rvalid, oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [DW-1:0] mdl [1 << AW];

  always #10 clk = ~clk;

  burst_sram #(.AW(AW), .DW(DW), .NB(NB)) dut (
    .clk_i(clk), .rst_ni(rst_n), .ld_ni(ld_n), .rw_i(rw), .addr_i(addr),
    .wdata_i(wdata), .bw_ni(bw_n), .rdata_o(rdata), .rvalid_o(rvalid), .oe_o(oe)
  );

  task automatic check(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < (1 << AW); i++) mdl[i] = '0;
  endtask

  // R1 R3 R4: write burst, data beat k = base + k*0x11111111
  task automatic wr_burst(input logic [AW-1:0] a, input logic [DW-1:0] base, input logic [NB-1:0] bw);
    for (int k = 0; k < 4; k++) begin
      logic [1:0] o;
      logic [DW-1:0] d;
      @(negedge clk);
      o = a[1:0] + 2'(k);
      d = base + DW'(k) * 32'h1111_1111;
      ld_n = (k == 0) ? 1'b0 : 1'b1;
      rw = 1'b0;
      addr = a;
      wdata = d;
      bw_n = bw;
      for (int b = 0; b < NB; b++)
        if (!bw[b]) mdl[{a[AW-1:2], o}][b*8 +: 8] = d[b*8 +: 8];
    end
  endtask

  // R2 R3 R6 R8: read burst, beat k checked in the cycle after beat k
  task automatic rd_burst(input logic [AW-1:0] a);
    @(negedge clk);
    ld_n = 1'b0;
    rw = 1'b1;
    addr = a;
    for (int k = 0; k < 4; k++) begin
      logic [1:0] o;
      @(negedge clk);
      if (k == 0) ld_n = 1'b1;
      o = a[1:0] + 2'(k);
      check(rdata, mdl[{a[AW-1:2], o}], "R6 read data");
      check(DW'(rvalid), 1, "R8 rvalid");
      check(DW'(oe), 1, "R8 oe");
    end
  endtask

  task automatic idle_chk(input string req);
    @(negedge clk);
    check(DW'(oe), 0, req);
    check(DW'(rvalid), 0, req);
    check(rdata, '0, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    check(DW'(oe), 0, "R10 oe in reset");
    check(rdata, '0, "R10 rdata in reset");
    rst_n = 1'b1;
    idle_chk("R10 idle after reset");
    idle_chk("R7 idle");

    for (int i = 0; i < NV; i++) begin
      logic [43:0] v;
      v = VEC[i];
      if (v[43:42] == 2'd1) wr_burst(v[41:36], v[35:4], v[3:0]);
      else rd_burst(v[41:36]);
    end
    idle_chk("R7 idle after read");

    // R9: deselected cycles with write data present change nothing
    @(negedge clk);
    ld_n = 1'b1; rw = 1'b0; addr = 6'h04; wdata = 32'hDEAD_BEEF; bw_n = '0;
    repeat (3) @(negedge clk);
    check(DW'(oe), 0, "R9 deselect idle");
    rd_burst(6'h04);

    // R9: strobe pulled low with a write inside a running read burst is ignored
    @(negedge clk);
    ld_n = 1'b0; rw = 1'b1; addr = 6'h08;
    for (int k = 0; k < 4; k++) begin
      logic [1:0] o;
      @(negedge clk);
      o = 2'(k);
      check(rdata, mdl[{4'h2, o}], "R9 read during stray strobe");
      ld_n = (k == 3) ? 1'b1 : 1'b0;
      rw = 1'b0; addr = 6'h08; wdata = 32'hBAD0_BAD0; bw_n = '0;
    end
    rd_burst(6'h08);

    // R6: back-to-back write then read of same words, masked pending merge
    wr_burst(6'h09, 32'h0F0F_0F0F, 4'b1010);
    rd_burst(6'h09);
    wr_burst(6'h3E, 32'h5555_AAAA, 4'b1110);
    rd_burst(6'h3D);

    // R10: reset again empties buffer and array
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(DW'(rvalid), 0, "R10 rvalid in reset");
    rst_n = 1'b1;
    model_clear();
    rd_burst(6'h09);
    rd_burst(6'h3C);
    idle_chk("R7 final idle");

    finish_run();
  end
endmodule